// File: doc/BRIEF.md
# Display Window Line Address Generator

This block works out where in memory each display line of one on-screen window begins. It counts lines from the vertical sync edge, decides whether the current line lies inside the window's vertical range, and for every such line issues a one-cycle fetch request. Each request carries the line's start address, its horizontal start position and its pixel count. A separate memory fetch engine consumes these requests.

The stored image can be laid out in two ways. In field layout each stored line is shown once per field. In frame layout a progressive image is split across the two fields of an interlaced scan: field 0 shows the even stored lines and field 1 shows the odd ones. The block picks the first-line address and the per-line address step to match the layout, the encoder scan type and the field being shown. All configuration, including the field ID, is captured at the vertical sync edge, so register writes made during a frame never tear the picture.

Top module: `win_line_addr_gen`

## Requirements
- R1: After reset `req_valid`, `line_in_window` and `req_addr` are 0, and the captured window height is 0. Until the first `vsync_edge`, no request is issued for any `hsync_edge`.
- R2: The base address is `{cfg_base_hi, cfg_base_lo}`, with the high part above bit 15. The carry from `cfg_base_lo` plus the line steps goes into the high bits, and the address wraps modulo 2^23.
- R3: Line index L counts `hsync_edge` pulses since the latest `vsync_edge`, and the first such pulse is L=0. The index saturates at 4095. A line is inside the window when y_start <= L < y_start + y_len. For such a line, `req_valid` is high for exactly the one cycle after the `hsync_edge` cycle. `line_in_window` shows the in-window decision from that same cycle until the next sync edge.
- R4: Every request carries `req_count` = x length and `req_xpos` = x start, both as captured at the vertical sync edge.
- R5: When `cfg_frame_layout`=0 (field layout), window row r (r = L - y_start) reads base + r*stride, whatever the field ID or scan type.
- R6: When `cfg_frame_layout`=1 and `cfg_progressive`=0, row r reads base + F*stride + 2*r*stride, where F is the captured field ID (0 or 1).
- R7: When `cfg_frame_layout`=1 and `cfg_progressive`=1, the layout bit is ignored and addresses follow R5.
- R8: All cfg_* inputs and `field_id` are sampled only in a cycle where `vsync_edge` is high. Changes to them at any other time have no effect until the next `vsync_edge`.
- R9: A `vsync_edge` always wins over an `hsync_edge` in the same cycle. That hsync is not counted as a line and raises no request, and the vsync clears `line_in_window`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base_lo | input | 16 | Base address, low 16 bits |
| cfg_base_hi | input | 7 | Base address, upper bits |
| cfg_stride | input | 16 | Memory distance between stored lines |
| cfg_x_start | input | 12 | Horizontal start from hsync leading edge |
| cfg_x_len | input | 12 | Pixels per line |
| cfg_y_start | input | 12 | First window line, counted from vsync |
| cfg_y_len | input | 12 | Window height in lines (per field when interlaced, per frame when progressive) |
| cfg_frame_layout | input | 1 | 1 = frame layout, 0 = field layout |
| cfg_progressive | input | 1 | 1 = progressive encoder, 0 = interlaced |
| field_id | input | 1 | Field being displayed |
| hsync_edge | input | 1 | One-cycle pulse at the horizontal sync leading edge |
| vsync_edge | input | 1 | One-cycle pulse at the vertical sync leading edge |
| req_valid | output | 1 | Line fetch request strobe |
| req_addr | output | 23 | Start address of the line fetch |
| req_xpos | output | 12 | Horizontal start of the fetched line |
| req_count | output | 12 | Pixel count of the fetched line |
| line_in_window | output | 1 | Current line lies inside the window |

## Verification
The hardest case to reach is a mid-field configuration change that would corrupt the running address pointer. The stimulus covers it by scrambling every cfg input and flipping `field_id` right after each vertical sync edge in every random frame. It also collides a vertical sync with a horizontal sync while the window is open, then confirms that the next line restarts at index 0. Field 1 of frame layout is driven both in random frames and in a directed run to show the one-stride offset.

// File: rtl/dwl_pkg.sv
package dwl_pkg;
    localparam int LO_W     = 16;
    localparam int HI_W     = 7;
    localparam int ADDR_W   = LO_W + HI_W;
    localparam int STRIDE_W = 16;
    localparam int POS_W    = 12;
    localparam int LINE_W   = 12;

    typedef logic [ADDR_W-1:0]   addr_t;
    typedef logic [STRIDE_W-1:0] stride_t;
    typedef logic [POS_W-1:0]    pos_t;
    typedef logic [LINE_W-1:0]   line_t;

    typedef enum logic {LAYOUT_FIELD = 1'b0, LAYOUT_FRAME = 1'b1} layout_e;
    typedef enum logic {SCAN_INTERLACED = 1'b0, SCAN_PROGRESSIVE = 1'b1} scan_e;

    typedef struct packed {
        addr_t   base;
        stride_t stride;
        pos_t    x_start;
        pos_t    x_len;
        pos_t    y_start;
        pos_t    y_len;
        layout_e layout;
        scan_e   scan;
    } win_cfg_t;

    typedef struct packed {
        logic  valid;
        addr_t addr;
        pos_t  xpos;
        pos_t  count;
    } line_req_t;

    function automatic addr_t join_base(input logic [HI_W-1:0] hi, input logic [LO_W-1:0] lo);
        return {hi, lo};
    endfunction

    // Frame layout only weaves the fields on an interlaced scan.
    function automatic logic weaves(input win_cfg_t c);
        return (c.layout == LAYOUT_FRAME) && (c.scan == SCAN_INTERLACED);
    endfunction

    function automatic addr_t first_addr(input win_cfg_t c, input logic fld);
        addr_t off;
        off = (weaves(c) && fld) ? addr_t'(c.stride) : '0;
        return c.base + off;
    endfunction

    function automatic addr_t line_step(input win_cfg_t c);
        return weaves(c) ? (addr_t'(c.stride) << 1) : addr_t'(c.stride);
    endfunction
endpackage

// File: rtl/dwl_cfg_shadow.sv
module dwl_cfg_shadow
    import dwl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     vsync_edge,
    input  win_cfg_t cfg_in,
    output win_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (vsync_edge) begin
            cfg_q <= cfg_in;
        end
    end

    // R8: captured configuration moves only at a vertical sync edge
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !vsync_edge |=> $stable(cfg_q));
endmodule

// File: rtl/dwl_line_track.sv
module dwl_line_track
    import dwl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic vsync_edge,
    input  logic hsync_edge,
    input  pos_t y_start,
    input  pos_t y_len,
    output logic line_hit,
    output logic in_window
);
    localparam int    CW       = (LINE_W > POS_W ? LINE_W : POS_W) + 1;
    localparam line_t LINE_MAX = '1;

    line_t           line_q;
    logic [CW-1:0]   line_x;
    logic [CW-1:0]   ys_x;
    logic [CW-1:0]   yl_x;
    logic            in_range;

    assign line_x   = CW'(line_q);
    assign ys_x     = CW'(y_start);
    assign yl_x     = CW'(y_len);
    assign in_range = (line_x >= ys_x) && ((line_x - ys_x) < yl_x);
    assign line_hit = hsync_edge && !vsync_edge && in_range;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q    <= '0;
            in_window <= 1'b0;
        end else if (vsync_edge) begin
            line_q    <= '0;
            in_window <= 1'b0;
        end else if (hsync_edge) begin
            in_window <= in_range;
            if (line_q != LINE_MAX) line_q <= line_q + 1'b1;
        end
    end

    // R3: line index saturates instead of wrapping
    p_line_sat_r3: assert property (@(posedge clk) disable iff (rst)
        (line_q == LINE_MAX && !vsync_edge) |=> line_q == LINE_MAX);
endmodule

// File: rtl/dwl_addr_step.sv
module dwl_addr_step
    import dwl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  addr_t load_addr,
    input  addr_t load_step,
    input  logic  advance,
    output addr_t ptr
);
    addr_t step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr    <= '0;
            step_q <= '0;
        end else if (load) begin
            ptr    <= load_addr;
            step_q <= load_step;
        end else if (advance) begin
            ptr    <= ptr + step_q;
        end
    end
endmodule

// File: rtl/win_line_addr_gen.sv
module win_line_addr_gen
    import dwl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [LO_W-1:0]     cfg_base_lo,
    input  logic [HI_W-1:0]     cfg_base_hi,
    input  logic [STRIDE_W-1:0] cfg_stride,
    input  logic [POS_W-1:0]    cfg_x_start,
    input  logic [POS_W-1:0]    cfg_x_len,
    input  logic [POS_W-1:0]    cfg_y_start,
    input  logic [POS_W-1:0]    cfg_y_len,
    input  logic                cfg_frame_layout,
    input  logic                cfg_progressive,
    input  logic                field_id,
    input  logic                hsync_edge,
    input  logic                vsync_edge,
    output logic                req_valid,
    output logic [ADDR_W-1:0]   req_addr,
    output logic [POS_W-1:0]    req_xpos,
    output logic [POS_W-1:0]    req_count,
    output logic                line_in_window
);
    win_cfg_t  cfg_raw;
    win_cfg_t  cfg_sh;
    line_req_t req_q;
    logic      hit;
    addr_t     ptr;

    always_comb begin
        cfg_raw.base    = join_base(cfg_base_hi, cfg_base_lo);
        cfg_raw.stride  = cfg_stride;
        cfg_raw.x_start = cfg_x_start;
        cfg_raw.x_len   = cfg_x_len;
        cfg_raw.y_start = cfg_y_start;
        cfg_raw.y_len   = cfg_y_len;
        cfg_raw.layout  = layout_e'(cfg_frame_layout);
        cfg_raw.scan    = scan_e'(cfg_progressive);
    end

    dwl_cfg_shadow u_shadow (
        .clk        (clk),
        .rst        (rst),
        .vsync_edge (vsync_edge),
        .cfg_in     (cfg_raw),
        .cfg_q      (cfg_sh)
    );

    dwl_line_track u_track (
        .clk        (clk),
        .rst        (rst),
        .vsync_edge (vsync_edge),
        .hsync_edge (hsync_edge),
        .y_start    (cfg_sh.y_start),
        .y_len      (cfg_sh.y_len),
        .line_hit   (hit),
        .in_window  (line_in_window)
    );

    dwl_addr_step u_step (
        .clk       (clk),
        .rst       (rst),
        .load      (vsync_edge),
        .load_addr (first_addr(cfg_raw, field_id)),
        .load_step (line_step(cfg_raw)),
        .advance   (hit),
        .ptr       (ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else begin
            req_q.valid <= hit;
            if (hit) begin
                req_q.addr  <= ptr;
                req_q.xpos  <= cfg_sh.x_start;
                req_q.count <= cfg_sh.x_len;
            end
        end
    end

    assign req_valid = req_q.valid;
    assign req_addr  = req_q.addr;
    assign req_xpos  = req_q.xpos;
    assign req_count = req_q.count;

    // R3: a request follows a horizontal sync edge that was not overridden by vsync
    p_req_after_hsync_r3: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ($past(hsync_edge) && !$past(vsync_edge)));

    // R3: a request only ever belongs to an in-window line
    p_req_in_window_r3: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> line_in_window);

    // R9: a vertical sync leaves no request and closes the window
    p_vsync_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        vsync_edge |=> (!req_valid && !line_in_window));
endmodule

// File: tb/tb_win_line_addr_gen.sv
module tb_win_line_addr_gen;
    import dwl_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [LO_W-1:0]     cfg_base_lo = '0;
    logic [HI_W-1:0]     cfg_base_hi = '0;
    logic [STRIDE_W-1:0] cfg_stride = '0;
    logic [POS_W-1:0]    cfg_x_start = '0, cfg_x_len = '0, cfg_y_start = '0, cfg_y_len = '0;
    logic cfg_frame_layout = 1'b0, cfg_progressive = 1'b0, field_id = 1'b0;
    logic hsync_edge = 1'b0, vsync_edge = 1'b0;
    logic req_valid, line_in_window;
    logic [ADDR_W-1:0] req_addr;
    logic [POS_W-1:0]  req_xpos, req_count;

    always #4 clk = ~clk;

    win_line_addr_gen dut (.*);

    int n_checks = 0;
    int n_fail = 0;

    // bench model of the captured state
    longint m_base, m_stride;
    int m_xs, m_xl, m_ys, m_yl, m_line, m_row;
    bit m_frame, m_prog, m_fld;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic longint exp_addr(input int r);
        longint a;
        bit w;
        w = m_frame && !m_prog;
        a = m_base + ((w && m_fld) ? m_stride : 0) + longint'(r) * (w ? 2 : 1) * m_stride;
        return a & ((longint'(1) << ADDR_W) - 1);
    endfunction

    function automatic string mode_tag();
        if (m_frame && !m_prog) return "R6";
        if (m_frame && m_prog)  return "R7";
        return "R5";
    endfunction

    task automatic do_vsync();
        @(negedge clk);
        vsync_edge = 1'b1;
        m_base  = longint'({cfg_base_hi, cfg_base_lo});
        m_stride = longint'(cfg_stride);
        m_xs = int'(cfg_x_start); m_xl = int'(cfg_x_len);
        m_ys = int'(cfg_y_start); m_yl = int'(cfg_y_len);
        m_frame = cfg_frame_layout; m_prog = cfg_progressive; m_fld = field_id;
        m_line = 0; m_row = 0;
        @(negedge clk);
        vsync_edge = 1'b0;
    endtask

    task automatic do_line(input string tag);
        bit hit;
        string t;
        hit = (m_line >= m_ys) && (m_line - m_ys < m_yl);
        @(negedge clk);
        hsync_edge = 1'b1;
        @(negedge clk);
        hsync_edge = 1'b0;
        chk(req_valid == hit, "R3", "req_valid", longint'(req_valid), longint'(hit));
        chk(line_in_window == hit, "R3", "line_in_window", longint'(line_in_window), longint'(hit));
        if (hit && req_valid) begin
            t = (tag != "") ? tag : mode_tag();
            chk(longint'(req_addr) == exp_addr(m_row), t, "req_addr",
                longint'(req_addr), exp_addr(m_row));
            chk(int'(req_count) == m_xl, "R4", "req_count", longint'(req_count), longint'(m_xl));
            chk(int'(req_xpos) == m_xs, "R4", "req_xpos", longint'(req_xpos), longint'(m_xs));
        end
        if (hit) m_row++;
        m_line++;
        @(negedge clk);
        chk(req_valid == 1'b0, "R3", "req_valid one-cycle", longint'(req_valid), 0);
    endtask

    task automatic rand_cfg();
        cfg_base_lo = 16'($urandom);
        cfg_base_hi = HI_W'($urandom);
        cfg_stride  = 16'($urandom);
        cfg_x_start = POS_W'($urandom);
        cfg_x_len   = POS_W'($urandom);
        cfg_y_start = POS_W'($urandom_range(0, 4));
        cfg_y_len   = POS_W'($urandom_range(0, 7));
        cfg_frame_layout = 1'($urandom);
        cfg_progressive  = 1'($urandom);
        field_id         = 1'($urandom);
    endtask

    task automatic set_cfg(input longint base, input int stride, input int ys, input int yl,
                           input bit frame, input bit prog, input bit fld);
        cfg_base_lo = base[15:0];
        cfg_base_hi = base[LO_W +: HI_W];
        cfg_stride  = 16'(stride);
        cfg_x_start = 12'd40;
        cfg_x_len   = 12'd720;
        cfg_y_start = 12'(ys);
        cfg_y_len   = 12'(yl);
        cfg_frame_layout = frame;
        cfg_progressive  = prog;
        field_id         = fld;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(req_valid == 1'b0, "R1", "req_valid after reset", longint'(req_valid), 0);
        chk(line_in_window == 1'b0, "R1", "in_window after reset", longint'(line_in_window), 0);
        chk(req_addr == '0, "R1", "req_addr after reset", longint'(req_addr), 0);
        // R1: no requests before the first vsync even with a window programmed
        set_cfg(64'h100, 16, 0, 5, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); hsync_edge = 1'b1;
            @(negedge clk); hsync_edge = 1'b0;
            chk(req_valid == 1'b0, "R1", "request before first vsync", longint'(req_valid), 0);
        end

        // R2: base join and carry from low into high part
        set_cfg({7'h5A, 16'hFFFE}, 1, 0, 3, 1'b0, 1'b0, 1'b0);
        do_vsync();
        for (int i = 0; i < 4; i++) do_line("R2");
        // R2: wrap at the top of the address space
        set_cfg({7'h7F, 16'hFFF0}, 16'h0010, 0, 2, 1'b0, 1'b1, 1'b0);
        do_vsync();
        for (int i = 0; i < 3; i++) do_line("R2");

        // R6: frame layout interlaced, both fields
        set_cfg(64'h2000, 16'h0100, 2, 4, 1'b1, 1'b0, 1'b1);
        do_vsync();
        for (int i = 0; i < 8; i++) do_line("R6");
        set_cfg(64'h2000, 16'h0100, 2, 4, 1'b1, 1'b0, 1'b0);
        do_vsync();
        for (int i = 0; i < 8; i++) do_line("R6");

        // R7: frame layout bit ignored on a progressive scan
        set_cfg(64'h3000, 16'h0080, 1, 5, 1'b1, 1'b1, 1'b1);
        do_vsync();
        for (int i = 0; i < 7; i++) do_line("R7");

        // R5: field layout, field 1 re-reads the same lines
        set_cfg(64'h4000, 16'h0040, 0, 3, 1'b0, 1'b0, 1'b1);
        do_vsync();
        for (int i = 0; i < 4; i++) do_line("R5");

        // R8: mid-field writes have no effect until the next vsync
        set_cfg(64'h5000, 16'h0020, 1, 4, 1'b0, 1'b0, 1'b0);
        do_vsync();
        do_line("R8");
        set_cfg(64'h9999, 16'h0777, 0, 9, 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 5; i++) do_line("R8");
        do_vsync();
        for (int i = 0; i < 4; i++) do_line("R8");

        // R9: vsync colliding with hsync while window is open
        set_cfg(64'h6000, 16'h0010, 0, 1, 1'b0, 1'b0, 1'b0);
        do_vsync();
        do_line("R9");
        @(negedge clk); vsync_edge = 1'b1; hsync_edge = 1'b1;
        m_base = longint'({cfg_base_hi, cfg_base_lo}); m_stride = longint'(cfg_stride);
        m_line = 0; m_row = 0;
        @(negedge clk); vsync_edge = 1'b0; hsync_edge = 1'b0;
        chk(req_valid == 1'b0, "R9", "req on collided hsync", longint'(req_valid), 0);
        chk(line_in_window == 1'b0, "R9", "in_window after vsync", longint'(line_in_window), 0);
        do_line("R9");   // must be line 0 again, hence inside the window

        // random frames; every cfg input is scrambled right after each vsync (R8)
        for (int f = 0; f < 40; f++) begin
            rand_cfg();
            do_vsync();
            rand_cfg();
            for (int l = 0; l < 12; l++) do_line("");
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule